// File: doc/BRIEF.md
# Indexed-Enable Interrupt Controller Core

This block collects up to 128 level-sensitive interrupt lines and presents them to one processor through a single `irq` output and a 32-bit register bus. The bus has two windows: a global window and a per-CPU window. Software never edits bitmaps. To enable or disable a source, it writes the source's number to a global set or clear register. To mask or unmask a source for the CPU, it writes the number to a per-CPU set or clear register.

The CPU reads an acknowledge register to find out which line to service. The register returns the number of the lowest-numbered source that is pending, enabled and unmasked. When no such source exists, it returns the all-ones code 0x3FF. A global on/off bit gates delivery for the whole controller. A one-bit task-priority register lets the CPU hold off delivery to itself. In the surrounding system, source 4 usually carries the summary of an error-cause unit and source 96 the summary of a doorbell (message-signalled) unit. To this core they are ordinary lines.

Top module: `icx_core`

## Requirements
- R1: After reset the controller is off, every source is disabled and masked, and the task-priority bit is 0. So `irq` is 0 and the acknowledge register reads 0x3FF, even with all inputs high.
- R2: Bit 0 of the global register at offset 0x000 turns the controller on (1) or off (0). While it is off, `irq` is 0.
- R3: Writing N (N < NUM_SRC) to global offset 0x030 enables source N. Writing N to global offset 0x034 disables it. All other sources are unchanged.
- R4: Writing N to per-CPU offset 0x0B8 masks source N. Writing N to per-CPU offset 0x0BC unmasks it. All other sources are unchanged.
- R5: Reading per-CPU offset 0x0B4 returns, in bits [9:0], the lowest-numbered source that is high, enabled and unmasked. Bits [31:10] read 0.
- R6: When no source is high, enabled and unmasked, the acknowledge read returns 0x3FF.
- R7: Bit 0 of per-CPU offset 0x0B0 is the task-priority bit. When it is 1, `irq` is 0. The acknowledge value does not depend on this bit or on the on/off bit.
- R8: `irq` is 1 exactly when the controller is on, the task-priority bit is 0, and at least one source is high, enabled and unmasked.
- R9: A set or clear write whose 32-bit value is NUM_SRC or more changes nothing.
- R10: Reads of the four set/clear registers return 0. The on/off and task-priority registers read back their bit 0 with all other bits 0.
- R11: Read data appears on `bus_rdata` in the cycle after the cycle in which `bus_rd` is sampled high. It holds until the next read.
- R12: Sources are level-sensitive. Nothing is latched, so a source that drops stops counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_cpu_win | input | 1 | 0 selects the global window, 1 the per-CPU window |
| bus_addr | input | 12 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_lvl | input | NUM_SRC | Level interrupt inputs |
| irq | output | 1 | Interrupt request to the CPU |

## Verification
The assertions assume that the bus strobes are known after reset and that `bus_wr` and `bus_rd` are never high in the same cycle. The bench drives each strobe alone, for one cycle, between falling edges. The assertions also assume that `src_lvl` changes only between edges. The bench changes it only at falling edges and then waits at least one edge before reading the acknowledge register. No assertion assumes that write values are in range: the bench deliberately writes indices at and above NUM_SRC and all-ones words.

// File: rtl/icx_pkg.sv
package icx_pkg;
   localparam int ID_W    = 10;
   localparam int ADDR_W  = 12;
   localparam int DATA_W  = 32;
   localparam logic [ID_W-1:0] ID_NONE = '1;

   // global window offsets
   localparam logic [ADDR_W-1:0] OFS_ONOFF  = 12'h000;
   localparam logic [ADDR_W-1:0] OFS_EN_SET = 12'h030;
   localparam logic [ADDR_W-1:0] OFS_EN_CLR = 12'h034;
   // per-CPU window offsets
   localparam logic [ADDR_W-1:0] OFS_TPRI   = 12'h0B0;
   localparam logic [ADDR_W-1:0] OFS_ACK    = 12'h0B4;
   localparam logic [ADDR_W-1:0] OFS_MK_SET = 12'h0B8;
   localparam logic [ADDR_W-1:0] OFS_MK_CLR = 12'h0BC;

   typedef enum logic {WIN_GLOBAL = 1'b0, WIN_CPU = 1'b1} win_e;
endpackage

// File: rtl/icx_regs.sv
module icx_regs
   import icx_pkg::*;
#(
   parameter int NUM_SRC = 128
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr,
   input  logic                cpu_win,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [DATA_W-1:0]   wdata,
   output logic                on,
   output logic                tpri,
   output logic [NUM_SRC-1:0]  en_vec,
   output logic [NUM_SRC-1:0]  mk_vec
);
   localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

   logic               idx_ok;
   logic [IDX_W-1:0]   idx;
   logic               w_on, w_tp, w_es, w_ec, w_ms, w_mc;

   assign idx_ok = (wdata < DATA_W'(NUM_SRC));
   assign idx    = wdata[IDX_W-1:0];

   always_comb begin
      w_on = wr && (cpu_win == WIN_GLOBAL) && (addr == OFS_ONOFF);
      w_es = wr && (cpu_win == WIN_GLOBAL) && (addr == OFS_EN_SET) && idx_ok;
      w_ec = wr && (cpu_win == WIN_GLOBAL) && (addr == OFS_EN_CLR) && idx_ok;
      w_tp = wr && (cpu_win == WIN_CPU)    && (addr == OFS_TPRI);
      w_ms = wr && (cpu_win == WIN_CPU)    && (addr == OFS_MK_SET) && idx_ok;
      w_mc = wr && (cpu_win == WIN_CPU)    && (addr == OFS_MK_CLR) && idx_ok;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         on   <= 1'b0;
         tpri <= 1'b0;
      end else begin
         if (w_on) on   <= wdata[0];
         if (w_tp) tpri <= wdata[0];
      end
   end

   genvar s;
   generate
      for (s = 0; s < NUM_SRC; s++) begin : g_bit
         logic hit;
         assign hit = (idx == IDX_W'(s));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_vec[s] <= 1'b0;
               mk_vec[s] <= 1'b1;
            end else begin
               if (hit && w_es)      en_vec[s] <= 1'b1;
               else if (hit && w_ec) en_vec[s] <= 1'b0;
               if (hit && w_ms)      mk_vec[s] <= 1'b1;
               else if (hit && w_mc) mk_vec[s] <= 1'b0;
            end
         end
      end
   endgenerate

   // R3
   en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_es |=> en_vec[$past(idx)]);
   // R3
   en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_ec |=> !en_vec[$past(idx)]);
   // R4
   mk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w_ms |=> mk_vec[$past(idx)]);
   // R9
   oob_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !idx_ok && addr != OFS_ONOFF && addr != OFS_TPRI)
      |=> ($stable(en_vec) && $stable(mk_vec)));
endmodule

// File: rtl/icx_arbiter.sv
module icx_arbiter
   import icx_pkg::*;
#(
   parameter int NUM_SRC = 128,
   parameter int GRP_W   = 8,
   parameter bit TREE    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  req,
   output logic                any,
   output logic [ID_W-1:0]     id
);
   localparam int NUM_GRP = NUM_SRC / GRP_W;
   localparam int LW      = (GRP_W > 1) ? $clog2(GRP_W) : 1;

   generate
      if (NUM_SRC < 1 || NUM_SRC > 1023) begin : g_bad_n
         $error("icx_arbiter: NUM_SRC must be 1..1023");
      end
      if (TREE && (GRP_W < 2 || (NUM_SRC % GRP_W) != 0)) begin : g_bad_g
         $error("icx_arbiter: GRP_W must be >=2 and divide NUM_SRC");
      end
   endgenerate

   logic [ID_W-1:0] win;

   generate
      if (TREE) begin : g_tree
         logic [NUM_GRP-1:0] grp_any;
         logic [LW-1:0]      grp_off [NUM_GRP];
         genvar g;
         for (g = 0; g < NUM_GRP; g++) begin : g_grp
            always_comb begin
               grp_any[g] = 1'b0;
               grp_off[g] = '0;
               for (int k = GRP_W - 1; k >= 0; k--) begin
                  if (req[g*GRP_W + k]) begin
                     grp_any[g] = 1'b1;
                     grp_off[g] = LW'(k);
                  end
               end
            end
         end
         always_comb begin
            any = 1'b0;
            win = '0;
            for (int j = NUM_GRP - 1; j >= 0; j--) begin
               if (grp_any[j]) begin
                  any = 1'b1;
                  win = ID_W'(j * GRP_W) + ID_W'(grp_off[j]);
               end
            end
         end
      end else begin : g_flat
         always_comb begin
            any = 1'b0;
            win = '0;
            for (int i = NUM_SRC - 1; i >= 0; i--) begin
               if (req[i]) begin
                  any = 1'b1;
                  win = ID_W'(i);
               end
            end
         end
      end
   endgenerate

   assign id = any ? win : ID_NONE;

   logic [NUM_SRC-1:0] below;
   assign below = ({{(NUM_SRC-1){1'b0}}, 1'b1} << id) - 1'b1;

   // R5
   pick_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> req[id]);
   // R5
   pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ((req & below) == '0));
   // R6
   none_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0) |-> (id == ID_NONE));
endmodule

// File: rtl/icx_core.sv
module icx_core
   import icx_pkg::*;
#(
   parameter int NUM_SRC = 128,
   parameter int GRP_W   = 8,
   parameter bit TREE    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr,
   input  logic                bus_rd,
   input  logic                bus_cpu_win,
   input  logic [11:0]         bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   input  logic [NUM_SRC-1:0]  src_lvl,
   output logic                irq
);
   logic               on, tpri, any;
   logic [NUM_SRC-1:0] en_vec, mk_vec, qual;
   logic [ID_W-1:0]    ack_id;
   logic [31:0]        rd_mux;

   icx_regs #(.NUM_SRC(NUM_SRC)) i_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .cpu_win(bus_cpu_win),
      .addr(bus_addr), .wdata(bus_wdata), .on(on), .tpri(tpri),
      .en_vec(en_vec), .mk_vec(mk_vec));

   assign qual = src_lvl & en_vec & ~mk_vec;

   icx_arbiter #(.NUM_SRC(NUM_SRC), .GRP_W(GRP_W), .TREE(TREE)) i_arb (
      .clk(clk), .rst_n(rst_n), .req(qual), .any(any), .id(ack_id));

   assign irq = on && !tpri && any;

   always_comb begin
      rd_mux = '0;
      if (bus_cpu_win == WIN_GLOBAL) begin
         if (bus_addr == OFS_ONOFF) rd_mux = {31'b0, on};
      end else begin
         if (bus_addr == OFS_TPRI)     rd_mux = {31'b0, tpri};
         else if (bus_addr == OFS_ACK) rd_mux = {{(32-ID_W){1'b0}}, ack_id};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   // R8
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (on && !tpri));
   // R7
   tpri_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tpri |-> !irq);
   // R10
   setclr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && ((bus_cpu_win == WIN_GLOBAL &&
                   (bus_addr == OFS_EN_SET || bus_addr == OFS_EN_CLR)) ||
                  (bus_cpu_win == WIN_CPU &&
                   (bus_addr == OFS_MK_SET || bus_addr == OFS_MK_CLR))))
      |=> (bus_rdata == 32'h0));
   // R11
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_icx_core.sv
module test_icx_core;
   localparam int N = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0, bus_rd = 1'b0, bus_cpu_win = 1'b0;
   logic [11:0]   bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  src_lvl = '0;
   logic          irq;

   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   icx_core #(.NUM_SRC(N)) i_icx_core (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_cpu_win(bus_cpu_win), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .src_lvl(src_lvl), .irq(irq));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(bit win, logic [11:0] a, logic [31:0] d);
      bus_cpu_win = win; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(bit win, logic [11:0] a, output logic [31:0] d);
      bus_cpu_win = win; bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_err++; n_chk++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, prev;
      src_lvl = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq", {31'b0, irq}, 0);
      rd(1, 12'h0B4, v); chk("R1 ack", v, 32'h3FF);
      rd(0, 12'h000, v); chk("R1 onoff", v, 0);
      rd(1, 12'h0B0, v); chk("R1 tpri", v, 0);
      // R2 turn on
      wr(0, 12'h000, 1);
      rd(0, 12'h000, v); chk("R10 onoff readback", v, 1);
      chk("R1 still masked", {31'b0, irq}, 0);
      // R10 set/clear reads
      rd(0, 12'h030, v); chk("R10 en_set read", v, 0);
      rd(0, 12'h034, v); chk("R10 en_clr read", v, 0);
      rd(1, 12'h0B8, v); chk("R10 mk_set read", v, 0);
      rd(1, 12'h0BC, v); chk("R10 mk_clr read", v, 0);
      // per-source sweep
      for (int s = 0; s < N; s++) begin
         src_lvl = '0; src_lvl[s] = 1'b1;
         wr(0, 12'h030, s);
         chk("R4 masked after enable", {31'b0, irq}, 0);
         wr(1, 12'h0BC, s);
         rd(1, 12'h0B4, v); chk("R5 single ack", v, s);
         chk("R8 irq", {31'b0, irq}, 1);
         wr(1, 12'h0B8, s);
         rd(1, 12'h0B4, v); chk("R4 mask", v, 32'h3FF);
         wr(0, 12'h034, s);
         wr(1, 12'h0BC, s);
         rd(1, 12'h0B4, v); chk("R3 disable", v, 32'h3FF);
         chk("R8 irq off", {31'b0, irq}, 0);
         wr(1, 12'h0B8, s);
      end
      // enable and unmask all
      for (int s = 0; s < N; s++) begin
         wr(0, 12'h030, s);
         wr(1, 12'h0BC, s);
      end
      // R5 lowest wins, R12 level follow
      for (int k = 0; k < N; k++) begin
         src_lvl = {N{1'b1}} << k;
         @(negedge clk);
         rd(1, 12'h0B4, v); chk("R5 lowest", v, k);
      end
      src_lvl = '0;
      @(negedge clk);
      chk("R12 drop irq", {31'b0, irq}, 0);
      rd(1, 12'h0B4, v); chk("R12 drop ack", v, 32'h3FF);
      // R7 task priority
      src_lvl = '1;
      @(negedge clk);
      chk("R8 all on", {31'b0, irq}, 1);
      wr(1, 12'h0B0, 1);
      chk("R7 blocked", {31'b0, irq}, 0);
      rd(1, 12'h0B4, v); chk("R7 ack unaffected", v, 0);
      prev = v;
      rd(1, 12'h0B0, v); chk("R11 next-cycle data", v, 1);
      chk("R11 changed from ack", {31'b0, v != prev}, 1);
      wr(1, 12'h0B0, 0);
      chk("R7 released", {31'b0, irq}, 1);
      // R2 off
      wr(0, 12'h000, 0);
      chk("R2 off irq", {31'b0, irq}, 0);
      rd(1, 12'h0B4, v); chk("R7 ack while off", v, 0);
      wr(0, 12'h000, 1);
      // R9 out of range
      wr(0, 12'h034, N);
      wr(0, 12'h034, 32'h200);
      wr(1, 12'h0B8, 32'hFFFF_FFFF);
      wr(1, 12'h0B8, N + 1000);
      rd(1, 12'h0B4, v); chk("R9 oob ignored", v, 0);
      chk("R9 irq kept", {31'b0, irq}, 1);
      // R3/R4 others untouched
      wr(0, 12'h034, 0);
      rd(1, 12'h0B4, v); chk("R3 next source", v, 1);
      wr(1, 12'h0B8, 1);
      rd(1, 12'h0B4, v); chk("R4 next source", v, 2);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule